// File: doc/BRIEF.md
# Three-Domain Command Decoder and Distributor

This block takes byte-wide commands from a stream source clocked by a network clock. It turns them into events and settings for two converter sides, each of which runs on its own asynchronous clock. Three opcodes are understood:

- A soft reset, which makes one reset pulse on each converter side.
- A start, which makes one start pulse on each converter side.
- A configuration load, which carries a 12-byte payload. The payload holds pulse width, pulse period, pulse count and raw amplitude. Its fields are delivered to the DAC side and to the ADC side as complete sets.

After a start, the block refuses further bytes until a completion pulse from the ADC side has been carried back into the network domain. Upstream data is therefore held back, not lost. Events and configuration words cross the clock domains through handshaked crossings, so every command produces exactly one effect whatever the clock ratio. While a crossing is still in flight, the stream input also holds off.

Top module: `cmd_fanout`

## Requirements
- R1: After reset every configuration output is zero, no event pulse is present, and `s_axis_tready` is high.
- R2: A single byte 0x0F that carries `s_axis_tlast` produces exactly one `dac_rst_o` pulse, one `clk_dac` cycle long. It also produces exactly one `adc_rst_o` pulse, one `clk_adc` cycle long.
- R3: A single byte 0xF0 that carries `s_axis_tlast` produces exactly one `dac_start_o` pulse and exactly one `adc_start_o` pulse, each one cycle of its own clock, and puts the block into the busy state.
- R4: Byte 0x88 followed by 12 payload bytes, least significant byte first, with `s_axis_tlast` on the 12th payload byte, loads the configuration. The payload fields are:
  - bits [31:0]: width;
  - bits [63:32]: period;
  - bits [79:64]: count;
  - bits [95:80]: raw amplitude.

  The DAC side receives width, period, count and amplitude, and updates them together in one clock. The ADC side receives period and count, and updates them together in one clock.
- R5: `dac_amp_o` is the low DAC_DATA_WIDTH (default 12) bits of the raw amplitude; raw 0x5CDE gives 0xCDE.
- R6: From a start until an `adc_done` pulse (one `clk_adc` cycle) has crossed back, `s_axis_tready` is low and an offered byte is held without effect. After that, the held byte is accepted and acted on.
- R7: A load whose `s_axis_tlast` comes before the 12th payload byte, or is missing from it, is dropped up to and including its `s_axis_tlast` byte, and no configuration output changes.
- R8: An unknown opcode is dropped up to and including its `s_axis_tlast` byte, even if later bytes look like opcodes. A 0x0F or 0xF0 without `s_axis_tlast` is dropped the same way. Neither case produces any event pulse.
- R9: Commands sent back to back each produce their own pulses; none is merged or lost.
- R10: An `adc_done` pulse while not busy has no effect: `s_axis_tready` stays high and later commands behave normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_net | input | 1 | Network domain clock |
| clk_dac | input | 1 | DAC domain clock |
| clk_adc | input | 1 | ADC domain clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| s_axis_tdata | input | 8 | Command stream byte |
| s_axis_tvalid | input | 1 | Command byte valid |
| s_axis_tready | output | 1 | Block can accept a byte |
| s_axis_tlast | input | 1 | Last byte of a command |
| adc_done | input | 1 | Completion pulse, ADC domain |
| dac_width_o | output | 32 | Pulse width, DAC domain |
| dac_period_o | output | 32 | Pulse period, DAC domain |
| dac_count_o | output | 16 | Pulse count, DAC domain |
| dac_amp_o | output | DAC_DATA_WIDTH | Pulse amplitude, DAC domain |
| adc_period_o | output | 32 | Pulse period, ADC domain |
| adc_count_o | output | 16 | Pulse count, ADC domain |
| dac_rst_o | output | 1 | Soft reset pulse, DAC domain |
| dac_start_o | output | 1 | Start pulse, DAC domain |
| adc_rst_o | output | 1 | Soft reset pulse, ADC domain |
| adc_start_o | output | 1 | Start pulse, ADC domain |

## Verification
The bench goes after framing faults: short loads, over-long loads, a bare load opcode, unknown opcodes whose trailing bytes imitate commands, and single-byte opcodes lacking the end marker. A design that counted bytes wrongly, or resumed decoding inside a dropped frame, would show an unexpected configuration update or a stray reset pulse. Back-to-back resets are fired at the slow ADC clock, where a bare toggle crossing would merge two events into none. A byte is also held against the busy state: a design that accepted it early, or never released it after the completion pulse, would show its reset pulse at the wrong time or not at all. A scoreboard compares every configuration update as one whole set, so torn or duplicated updates show as mismatches.

// File: rtl/cmd_fanout_pkg.sv
package cmd_fanout_pkg;

  localparam logic [7:0] OP_SOFT_RESET = 8'h0F;
  localparam logic [7:0] OP_START      = 8'hF0;
  localparam logic [7:0] OP_LOAD       = 8'h88;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_PAYLOAD,
    PS_DISCARD,
    PS_BUSY
  } parse_st_t;

  typedef enum logic [1:0] {
    OPK_RESET,
    OPK_START,
    OPK_LOAD,
    OPK_OTHER
  } op_kind_t;

  function automatic op_kind_t classify_op(input logic [7:0] b);
    case (b)
      OP_SOFT_RESET: return OPK_RESET;
      OP_START:      return OPK_START;
      OP_LOAD:       return OPK_LOAD;
      default:       return OPK_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/cmd_fanout_parser.sv
module cmd_fanout_parser
  import cmd_fanout_pkg::*;
#(
  parameter int PAY_BYTES = 12,
  localparam int PAY_BITS = PAY_BYTES * 8,
  localparam int CNT_W = $clog2(PAY_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          tdata,
  input  logic                tvalid,
  input  logic                tlast,
  output logic                tready,
  input  logic                xfer_busy,
  input  logic                finish_evt,
  output logic                rst_evt,
  output logic                start_evt,
  output logic                load_evt,
  output logic [PAY_BITS-1:0] payload
);

  parse_st_t           st_q, st_d;
  logic [CNT_W-1:0]    idx_q, idx_d;
  logic [PAY_BITS-1:0] pay_q, pay_d;
  logic                beat;
  logic                last_idx;

  function automatic logic [PAY_BITS-1:0] put_byte(
    input logic [PAY_BITS-1:0] acc,
    input logic [7:0]          b,
    input logic [CNT_W-1:0]    pos
  );
    logic [PAY_BITS-1:0] r;
    r = acc;
    r[int'(pos)*8 +: 8] = b;
    return r;
  endfunction

  assign tready   = (st_q != PS_BUSY) && !xfer_busy;
  assign beat     = tvalid && tready;
  assign last_idx = (idx_q == CNT_W'(PAY_BYTES - 1));
  assign payload  = pay_d;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    pay_d     = pay_q;
    rst_evt   = 1'b0;
    start_evt = 1'b0;
    load_evt  = 1'b0;
    case (st_q)
      PS_IDLE: begin
        if (beat) begin
          case (classify_op(tdata))
            OPK_RESET: begin
              if (tlast) rst_evt = 1'b1;
              else       st_d = PS_DISCARD;
            end
            OPK_START: begin
              if (tlast) begin
                start_evt = 1'b1;
                st_d      = PS_BUSY;
              end else begin
                st_d = PS_DISCARD;
              end
            end
            OPK_LOAD: begin
              if (!tlast) begin
                st_d  = PS_PAYLOAD;
                idx_d = '0;
              end
            end
            default: begin
              if (!tlast) st_d = PS_DISCARD;
            end
          endcase
        end
      end
      PS_PAYLOAD: begin
        if (beat) begin
          pay_d = put_byte(pay_q, tdata, idx_q);
          idx_d = idx_q + CNT_W'(1);
          if (last_idx) begin
            if (tlast) begin
              load_evt = 1'b1;
              st_d     = PS_IDLE;
            end else begin
              st_d = PS_DISCARD;
            end
          end else if (tlast) begin
            st_d = PS_IDLE;
          end
        end
      end
      PS_DISCARD: begin
        if (beat && tlast) st_d = PS_IDLE;
      end
      PS_BUSY: begin
        if (finish_evt) st_d = PS_IDLE;
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      idx_q <= '0;
      pay_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      pay_q <= pay_d;
    end
  end

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st_q == PS_BUSY)); // R3

  AST_BUSY_UNTIL_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_BUSY && !finish_evt) |=> (st_q == PS_BUSY)); // R6

  AST_LOAD_ONLY_FROM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (st_q == PS_IDLE && $past(st_q) == PS_PAYLOAD)); // R4

endmodule

// File: rtl/cmd_fanout_pulse_xing.sv
module cmd_fanout_pulse_xing #(
  parameter int SYNC = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  output logic src_busy,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);

  logic            src_tgl_q;
  logic [SYNC-1:0] ack_sync_q;
  logic [SYNC-1:0] dst_sync_q;
  logic            dst_seen_q;

  assign src_busy  = src_tgl_q ^ ack_sync_q[SYNC-1];
  assign dst_pulse = dst_sync_q[SYNC-1] ^ dst_seen_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      src_tgl_q  <= 1'b0;
      ack_sync_q <= '0;
    end else begin
      if (src_pulse && !src_busy) src_tgl_q <= ~src_tgl_q;
      ack_sync_q <= {ack_sync_q[SYNC-2:0], dst_seen_q};
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      dst_sync_q <= '0;
      dst_seen_q <= 1'b0;
    end else begin
      dst_sync_q <= {dst_sync_q[SYNC-2:0], src_tgl_q};
      dst_seen_q <= dst_sync_q[SYNC-1];
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |=> !dst_pulse); // R2

  AST_SRC_RESPECTS_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_pulse |-> !src_busy); // R9

endmodule

// File: rtl/cmd_fanout_word_xing.sv
module cmd_fanout_word_xing #(
  parameter int W    = 48,
  parameter int SYNC = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_load,
  input  logic [W-1:0] src_data,
  output logic         src_busy,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_data
);

  logic [W-1:0]    hold_q;
  logic            req_q;
  logic [SYNC-1:0] ack_sync_q;
  logic [SYNC-1:0] req_sync_q;
  logic            req_seen_q;
  logic [W-1:0]    out_q;
  logic            dst_take;

  assign src_busy = req_q ^ ack_sync_q[SYNC-1];
  assign dst_take = req_sync_q[SYNC-1] ^ req_seen_q;
  assign dst_data = out_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      hold_q     <= '0;
      req_q      <= 1'b0;
      ack_sync_q <= '0;
    end else begin
      if (src_load && !src_busy) begin
        hold_q <= src_data;
        req_q  <= ~req_q;
      end
      ack_sync_q <= {ack_sync_q[SYNC-2:0], req_seen_q};
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_sync_q <= '0;
      req_seen_q <= 1'b0;
      out_q      <= '0;
    end else begin
      req_sync_q <= {req_sync_q[SYNC-2:0], req_q};
      req_seen_q <= req_sync_q[SYNC-1];
      if (dst_take) out_q <= hold_q;
    end
  end

  AST_LOAD_RESPECTS_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_load |-> !src_busy); // R9

  AST_SINGLE_TAKE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_take |=> !dst_take); // R4

endmodule

// File: rtl/cmd_fanout.sv
module cmd_fanout #(
  parameter int WIDTH_W        = 32,
  parameter int PERIOD_W       = 32,
  parameter int COUNT_W        = 16,
  parameter int AMP_RAW_W      = 16,
  parameter int DAC_DATA_WIDTH = 12,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                      clk_net,
  input  logic                      clk_dac,
  input  logic                      clk_adc,
  input  logic                      rst_n,
  input  logic [7:0]                s_axis_tdata,
  input  logic                      s_axis_tvalid,
  output logic                      s_axis_tready,
  input  logic                      s_axis_tlast,
  input  logic                      adc_done,
  output logic [WIDTH_W-1:0]        dac_width_o,
  output logic [PERIOD_W-1:0]       dac_period_o,
  output logic [COUNT_W-1:0]        dac_count_o,
  output logic [DAC_DATA_WIDTH-1:0] dac_amp_o,
  output logic [PERIOD_W-1:0]       adc_period_o,
  output logic [COUNT_W-1:0]        adc_count_o,
  output logic                      dac_rst_o,
  output logic                      dac_start_o,
  output logic                      adc_rst_o,
  output logic                      adc_start_o
);

  localparam int PAY_BITS  = WIDTH_W + PERIOD_W + COUNT_W + AMP_RAW_W;
  localparam int PAY_BYTES = PAY_BITS / 8;
  localparam int OFF_PER   = WIDTH_W;
  localparam int OFF_CNT   = OFF_PER + PERIOD_W;
  localparam int OFF_AMP   = OFF_CNT + COUNT_W;
  localparam int DAC_W     = WIDTH_W + PERIOD_W + COUNT_W + DAC_DATA_WIDTH;
  localparam int ADC_W     = PERIOD_W + COUNT_W;
  localparam int N_EVT     = 4;

  function automatic logic [DAC_DATA_WIDTH-1:0] amp_fit(input logic [AMP_RAW_W-1:0] raw);
    return raw[DAC_DATA_WIDTH-1:0];
  endfunction

  logic                rst_evt, start_evt, load_evt, finish_evt;
  logic [PAY_BITS-1:0] payload;
  logic [N_EVT-1:0]    evt_src, evt_busy, evt_out;
  logic                dac_cfg_busy, adc_cfg_busy, done_busy;
  logic                xfer_busy;
  logic [DAC_W-1:0]    dac_bundle, dac_cfg;
  logic [ADC_W-1:0]    adc_bundle, adc_cfg;

  cmd_fanout_parser #(.PAY_BYTES(PAY_BYTES)) u_parser (
    .clk        (clk_net),
    .rst_n      (rst_n),
    .tdata      (s_axis_tdata),
    .tvalid     (s_axis_tvalid),
    .tlast      (s_axis_tlast),
    .tready     (s_axis_tready),
    .xfer_busy  (xfer_busy),
    .finish_evt (finish_evt),
    .rst_evt    (rst_evt),
    .start_evt  (start_evt),
    .load_evt   (load_evt),
    .payload    (payload)
  );

  // event lanes: 0 dac reset, 1 dac start, 2 adc reset, 3 adc start
  assign evt_src = {start_evt, rst_evt, start_evt, rst_evt};

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    if (g < 2) begin : g_dac
      cmd_fanout_pulse_xing #(.SYNC(SYNC_STAGES)) u_xing (
        .src_clk   (clk_net),
        .src_rst_n (rst_n),
        .src_pulse (evt_src[g]),
        .src_busy  (evt_busy[g]),
        .dst_clk   (clk_dac),
        .dst_rst_n (rst_n),
        .dst_pulse (evt_out[g])
      );
    end else begin : g_adc
      cmd_fanout_pulse_xing #(.SYNC(SYNC_STAGES)) u_xing (
        .src_clk   (clk_net),
        .src_rst_n (rst_n),
        .src_pulse (evt_src[g]),
        .src_busy  (evt_busy[g]),
        .dst_clk   (clk_adc),
        .dst_rst_n (rst_n),
        .dst_pulse (evt_out[g])
      );
    end
  end

  assign dac_rst_o   = evt_out[0];
  assign dac_start_o = evt_out[1];
  assign adc_rst_o   = evt_out[2];
  assign adc_start_o = evt_out[3];

  cmd_fanout_pulse_xing #(.SYNC(SYNC_STAGES)) u_done_xing (
    .src_clk   (clk_adc),
    .src_rst_n (rst_n),
    .src_pulse (adc_done),
    .src_busy  (done_busy),
    .dst_clk   (clk_net),
    .dst_rst_n (rst_n),
    .dst_pulse (finish_evt)
  );

  assign dac_bundle = {amp_fit(payload[OFF_AMP +: AMP_RAW_W]),
                       payload[OFF_CNT +: COUNT_W],
                       payload[OFF_PER +: PERIOD_W],
                       payload[0 +: WIDTH_W]};
  assign adc_bundle = {payload[OFF_CNT +: COUNT_W], payload[OFF_PER +: PERIOD_W]};

  cmd_fanout_word_xing #(.W(DAC_W), .SYNC(SYNC_STAGES)) u_dac_cfg (
    .src_clk   (clk_net),
    .src_rst_n (rst_n),
    .src_load  (load_evt),
    .src_data  (dac_bundle),
    .src_busy  (dac_cfg_busy),
    .dst_clk   (clk_dac),
    .dst_rst_n (rst_n),
    .dst_data  (dac_cfg)
  );

  cmd_fanout_word_xing #(.W(ADC_W), .SYNC(SYNC_STAGES)) u_adc_cfg (
    .src_clk   (clk_net),
    .src_rst_n (rst_n),
    .src_load  (load_evt),
    .src_data  (adc_bundle),
    .src_busy  (adc_cfg_busy),
    .dst_clk   (clk_adc),
    .dst_rst_n (rst_n),
    .dst_data  (adc_cfg)
  );

  assign xfer_busy = (|evt_busy) | dac_cfg_busy | adc_cfg_busy;

  assign {dac_amp_o, dac_count_o, dac_period_o, dac_width_o} = dac_cfg;
  assign {adc_count_o, adc_period_o} = adc_cfg;

  AST_DONE_TAKEN: assert property (@(posedge clk_adc) disable iff (!rst_n)
    adc_done |=> done_busy); // R6

endmodule

// File: tb/cmd_fanout_bench.sv
`timescale 1ns/1ps
module cmd_fanout_bench;

  localparam int DW   = 12;
  localparam int DACV = 32 + 32 + 16 + DW;
  localparam int ADCV = 32 + 16;

  logic clk_net = 1'b0, clk_dac = 1'b0, clk_adc = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] s_axis_tdata = '0;
  logic s_axis_tvalid = 1'b0, s_axis_tlast = 1'b0, s_axis_tready;
  logic adc_done = 1'b0;
  logic [31:0] dac_width_o, dac_period_o, adc_period_o;
  logic [15:0] dac_count_o, adc_count_o;
  logic [DW-1:0] dac_amp_o;
  logic dac_rst_o, dac_start_o, adc_rst_o, adc_start_o;

  always #5.0  clk_net = ~clk_net;
  always #3.85 clk_dac = ~clk_dac;
  always #7.7  clk_adc = ~clk_adc;

  cmd_fanout #(.DAC_DATA_WIDTH(DW)) u_cmd_fanout (
    .clk_net, .clk_dac, .clk_adc, .rst_n,
    .s_axis_tdata, .s_axis_tvalid, .s_axis_tready, .s_axis_tlast,
    .adc_done,
    .dac_width_o, .dac_period_o, .dac_count_o, .dac_amp_o,
    .adc_period_o, .adc_count_o,
    .dac_rst_o, .dac_start_o, .adc_rst_o, .adc_start_o
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int c_dac_rst = 0, c_dac_start = 0, c_adc_rst = 0, c_adc_start = 0;
  int e_rst = 0, e_start = 0;
  logic [DACV-1:0] q_dac[$];
  logic [ADCV-1:0] q_adc[$];
  logic [DACV-1:0] dac_prev = '0;
  logic [ADCV-1:0] adc_prev = '0;
  logic [DACV-1:0] dac_now, exp_d;
  logic [ADCV-1:0] adc_now, exp_a;

  assign dac_now = {dac_amp_o, dac_count_o, dac_period_o, dac_width_o};
  assign adc_now = {adc_count_o, adc_period_o};

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // event pulse monitors, sampled mid-cycle
  always @(negedge clk_dac) if (rst_n) begin
    if (dac_rst_o) c_dac_rst++;
    if (dac_start_o) c_dac_start++;
  end
  always @(negedge clk_adc) if (rst_n) begin
    if (adc_rst_o) c_adc_rst++;
    if (adc_start_o) c_adc_start++;
  end

  // configuration scoreboard: every change must be the next expected whole set
  always @(negedge clk_dac) if (rst_n && dac_now !== dac_prev) begin
    if (q_dac.size() == 0) chk("R7 unexpected dac update", 96'(dac_now), 96'(dac_prev));
    else begin
      exp_d = q_dac.pop_front();
      chk("R4 dac set", 96'(dac_now), 96'(exp_d));
    end
    dac_prev = dac_now;
  end
  always @(negedge clk_adc) if (rst_n && adc_now !== adc_prev) begin
    if (q_adc.size() == 0) chk("R7 unexpected adc update", 96'(adc_now), 96'(adc_prev));
    else begin
      exp_a = q_adc.pop_front();
      chk("R4 adc set", 96'(adc_now), 96'(exp_a));
    end
    adc_prev = adc_now;
  end

  task automatic put_byte(input logic [7:0] b, input logic l);
    @(negedge clk_net);
    s_axis_tdata = b; s_axis_tvalid = 1'b1; s_axis_tlast = l;
  endtask

  task automatic wait_take();
    while (!s_axis_tready) @(negedge clk_net);
    @(posedge clk_net);
    #1;
    s_axis_tvalid = 1'b0; s_axis_tlast = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic l);
    put_byte(b, l);
    wait_take();
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_net);
  endtask

  task automatic send_load(input logic [31:0] w, input logic [31:0] p,
                           input logic [15:0] c, input logic [15:0] a);
    logic [95:0] pl;
    pl = {a, c, p, w};
    q_dac.push_back({a[DW-1:0], c, p, w});
    q_adc.push_back({c, p});
    send_byte(8'h88, 1'b0);
    for (int i = 0; i < 12; i++) send_byte(pl[i*8 +: 8], i == 11);
  endtask

  task automatic pulse_done();
    @(negedge clk_adc); adc_done = 1'b1;
    @(negedge clk_adc); adc_done = 1'b0;
  endtask

  task automatic chk_counts(input string tag);
    chk({tag, " dac rst"}, 96'(c_dac_rst), 96'(e_rst));
    chk({tag, " adc rst"}, 96'(c_adc_rst), 96'(e_rst));
    chk({tag, " dac start"}, 96'(c_dac_start), 96'(e_start));
    chk({tag, " adc start"}, 96'(c_adc_start), 96'(e_start));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_net);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    settle(5);
    rst_n = 1'b1;
    settle(2);
    // R1 reset state
    chk("R1 dac cfg zero", 96'(dac_now), 96'(0));
    chk("R1 adc cfg zero", 96'(adc_now), 96'(0));
    chk("R1 tready high", 96'(s_axis_tready), 96'(1));
    chk("R1 no pulses", 96'({dac_rst_o, dac_start_o, adc_rst_o, adc_start_o}), 96'(0));

    // R2 soft reset
    send_byte(8'h0F, 1'b1); e_rst++;
    settle(40);
    chk_counts("R2");

    // R4 / R5 load with upper amplitude bits set
    send_load(32'h1122_3344, 32'h5566_7788, 16'hA1B2, 16'h5CDE);
    settle(60);
    chk("R5 amp low bits", 96'(dac_amp_o), 96'(12'hCDE));
    chk("R4 adc period", 96'(adc_period_o), 96'(32'h5566_7788));
    chk("R4 dac queue drained", 96'(q_dac.size()), 96'(0));
    chk("R4 adc queue drained", 96'(q_adc.size()), 96'(0));

    // R7 short load, long load, bare opcode
    send_byte(8'h88, 1'b0);
    for (int i = 0; i < 5; i++) send_byte(8'hE0 + 8'(i), i == 4);
    send_byte(8'h88, 1'b0);
    for (int i = 0; i < 13; i++) send_byte(8'h30 + 8'(i), i == 12);
    send_byte(8'h88, 1'b1);
    settle(60);
    chk("R7 dac unchanged", 96'(dac_now), 96'({12'hCDE, 16'hA1B2, 32'h5566_7788, 32'h1122_3344}));
    chk("R7 adc unchanged", 96'(adc_now), 96'({16'hA1B2, 32'h5566_7788}));

    // R8 unknown opcode hiding commands, single-byte opcodes without end marker
    send_byte(8'h55, 1'b0); send_byte(8'h0F, 1'b0); send_byte(8'hF0, 1'b1);
    send_byte(8'h0F, 1'b0); send_byte(8'hAA, 1'b1);
    send_byte(8'hF0, 1'b0); send_byte(8'h0F, 1'b1);
    settle(40);
    chk_counts("R8");
    chk("R8 not busy", 96'(s_axis_tready), 96'(1));

    // R9 back-to-back resets and a load right after
    send_byte(8'h0F, 1'b1); send_byte(8'h0F, 1'b1); send_byte(8'h0F, 1'b1);
    e_rst += 3;
    send_load(32'hDEAD_0001, 32'h0000_0400, 16'h0007, 16'hF123);
    settle(80);
    chk_counts("R9");
    chk("R9 dac queue drained", 96'(q_dac.size()), 96'(0));

    // R3 start, R6 busy stall
    send_byte(8'hF0, 1'b1); e_start++;
    settle(40);
    chk_counts("R3");
    chk("R6 tready low while busy", 96'(s_axis_tready), 96'(0));
    put_byte(8'h0F, 1'b1);
    settle(30);
    chk("R6 held byte no effect", 96'(c_adc_rst), 96'(e_rst));
    chk("R6 still stalled", 96'(s_axis_tready), 96'(0));
    pulse_done();
    wait_take(); e_rst++;
    settle(40);
    chk_counts("R6");
    chk("R6 tready back", 96'(s_axis_tready), 96'(1));

    // R10 completion while idle
    pulse_done();
    settle(20);
    chk("R10 tready stays high", 96'(s_axis_tready), 96'(1));
    send_byte(8'h0F, 1'b1); e_rst++;
    send_load(32'h0000_0010, 32'hFFFF_FFFF, 16'hFFFF, 16'h0FFF);
    settle(80);
    chk_counts("R10");
    chk("R10 dac queue drained", 96'(q_dac.size()), 96'(0));
    chk("R10 adc queue drained", 96'(q_adc.size()), 96'(0));

    summary();
  end

endmodule